// File: doc/BRIEF.md
# Non-Overlapping Four-Phase Clock Generator

This block turns a fast master clock into four control phases for a switched-capacitor sampler and integrator: a main phase A, a late copy of A, a main phase B and a late copy of B. Each main phase is high for a set number of master cycles. Its late copy rises on the same edge, but stays high for a set trailing count after the main phase has dropped. This lets the main switch open before its partner, as bottom-plate sampling requires. Once the late copy falls, every output stays low for a set gap before the other pair rises. The two main phases therefore never overlap, and neither do the two late phases.

The master clock is an integer multiple of the phase rate, which is the modulator sampling rate (for example 220 kHz). The three counts are plain inputs measured in master cycles. They are sampled only when a new period begins, that is, on the edge where phase A rises. A value of zero is treated as one. One period lasts 2*(hold+trail+gap) master cycles.

The sequencer is a state machine with seven states. ST_IDLE is entered at reset. ST_A_ON has both A outputs high. ST_A_TAIL has only the late A output high. ST_A_GAP has all outputs low. ST_B_ON, ST_B_TAIL and ST_B_GAP do the same for the B pair.

The transitions are as follows:
- ST_IDLE moves to ST_A_ON on the first edge after reset ends.
- Each later state advances to the next one when its down-counter reaches zero.
- ST_B_GAP returns to ST_A_ON. That transition is the period start, where the settings are captured.

Top module: `four_phase_clkgen`

## Requirements
- R1: While rst_n is low, all four phase outputs are 0. They clear asynchronously.
- R2: phase_a and phase_b are never 1 in the same cycle.
- R3: phase_a_late and phase_b_late are never 1 in the same cycle.
- R4: Each late output rises on the same master edge as its main phase, and is 1 whenever its main phase is 1.
- R5: After a main phase falls, its late output stays 1 for exactly trail_cycles master cycles.
- R6: Each main phase is 1 for exactly hold_cycles master cycles per period.
- R7: After a late output falls, all outputs stay 0 for exactly gap_cycles master cycles. The other pair then rises.
- R8: A value of 0 on hold_cycles, trail_cycles or gap_cycles acts as 1.
- R9: The three counts are sampled on the edge where phase_a rises. A change at any other time takes effect only from the next rise of phase_a.
- R10: phase_a rises on the first master edge after rst_n goes high. The pairs alternate A then B, and phase_a rises every 2*(hold+trail+gap) master cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_cycles | input | CNT_W | Main phase high time, in master cycles |
| trail_cycles | input | CNT_W | Extra high time of each late phase, in master cycles |
| gap_cycles | input | CNT_W | Dead time between the pairs, in master cycles |
| phase_a | output | 1 | Main phase A |
| phase_a_late | output | 1 | Late copy of phase A |
| phase_b | output | 1 | Main phase B |
| phase_b_late | output | 1 | Late copy of phase B |

## Verification
The bench sweeps hold, trail and gap settings that include all-ones and all-zeros settings. A design that loaded its down-counters off by one would stretch or shrink every segment and change the measured period. A design that failed to clamp zeros would wrap its counter and stall for hundreds of cycles. A separate run changes all three counts while phase A's tail is in progress. A design that sampled the inputs continuously would shorten the B half of that period instead of waiting for the next rise of phase A. Reset is also asserted in the middle of a run. A design with a synchronous or missing output clear would leave a phase high for a cycle.

// File: rtl/ncg_pkg.sv
package ncg_pkg;

    // Sequencer states, one per segment of the period
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_A_ON   = 3'd1,
        ST_A_TAIL = 3'd2,
        ST_A_GAP  = 3'd3,
        ST_B_ON   = 3'd4,
        ST_B_TAIL = 3'd5,
        ST_B_GAP  = 3'd6
    } ncg_state_e;

    // Index of each timing field in the packed settings array
    localparam int FLD_HOLD  = 0;
    localparam int FLD_TRAIL = 1;
    localparam int FLD_GAP   = 2;
    localparam int FLD_NUM   = 3;

endpackage

// File: rtl/ncg_cfg_hold.sv
module ncg_cfg_hold
    import ncg_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            capture,
    input  logic [FLD_NUM-1:0][CNT_W-1:0]   raw_cfg,
    output logic [CNT_W-1:0]                hold_next,
    output logic [FLD_NUM-1:0][CNT_W-1:0]   cur_cfg
);

    localparam logic [CNT_W-1:0] MIN_CNT = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [FLD_NUM-1:0][CNT_W-1:0] clamped;

    // Zero is lifted to one on each field
    for (genvar f = 0; f < FLD_NUM; f++) begin : g_clamp
        assign clamped[f] = (raw_cfg[f] == '0) ? MIN_CNT : raw_cfg[f];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cur_cfg[f] <= MIN_CNT;
            end else if (capture) begin
                cur_cfg[f] <= clamped[f];
            end
        end
    end

    // The first segment of a new period needs the incoming hold value
    assign hold_next = clamped[FLD_HOLD];

endmodule

// File: rtl/ncg_seq_fsm.sv
module ncg_seq_fsm
    import ncg_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [CNT_W-1:0]                hold_next,
    input  logic [FLD_NUM-1:0][CNT_W-1:0]   cur_cfg,
    output ncg_state_e                      state_d,
    output logic                            period_start
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    ncg_state_e         state_q;
    logic [CNT_W-1:0]   seg_cnt;
    logic               seg_done;
    logic               seg_load;
    logic [CNT_W-1:0]   seg_len;

    assign seg_done = (seg_cnt == '0);

    // Next-state and segment-length selection
    always_comb begin
        state_d  = state_q;
        seg_load = 1'b0;
        seg_len  = '0;
        unique case (state_q)
            ST_IDLE: begin
                state_d  = ST_A_ON;
                seg_load = 1'b1;
                seg_len  = hold_next - ONE;
            end
            ST_A_ON: begin
                if (seg_done) begin
                    state_d  = ST_A_TAIL;
                    seg_load = 1'b1;
                    seg_len  = cur_cfg[FLD_TRAIL] - ONE;
                end
            end
            ST_A_TAIL: begin
                if (seg_done) begin
                    state_d  = ST_A_GAP;
                    seg_load = 1'b1;
                    seg_len  = cur_cfg[FLD_GAP] - ONE;
                end
            end
            ST_A_GAP: begin
                if (seg_done) begin
                    state_d  = ST_B_ON;
                    seg_load = 1'b1;
                    seg_len  = cur_cfg[FLD_HOLD] - ONE;
                end
            end
            ST_B_ON: begin
                if (seg_done) begin
                    state_d  = ST_B_TAIL;
                    seg_load = 1'b1;
                    seg_len  = cur_cfg[FLD_TRAIL] - ONE;
                end
            end
            ST_B_TAIL: begin
                if (seg_done) begin
                    state_d  = ST_B_GAP;
                    seg_load = 1'b1;
                    seg_len  = cur_cfg[FLD_GAP] - ONE;
                end
            end
            ST_B_GAP: begin
                if (seg_done) begin
                    state_d  = ST_A_ON;
                    seg_load = 1'b1;
                    seg_len  = hold_next - ONE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    assign period_start = (state_d == ST_A_ON) && (state_q != ST_A_ON);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Segment down-counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_cnt <= '0;
        end else if (seg_load) begin
            seg_cnt <= seg_len;
        end else if (!seg_done) begin
            seg_cnt <= seg_cnt - ONE;
        end
    end

endmodule

// File: rtl/ncg_phase_drive.sv
module ncg_phase_drive
    import ncg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  ncg_state_e  state_d,
    output logic        phase_a,
    output logic        phase_a_late,
    output logic        phase_b,
    output logic        phase_b_late
);

    logic [3:0] pat;

    // Bit order: {b_late, b, a_late, a}
    always_comb begin
        pat = 4'b0000;
        unique case (state_d)
            ST_IDLE:   pat = 4'b0000;
            ST_A_ON:   pat = 4'b0011;
            ST_A_TAIL: pat = 4'b0010;
            ST_A_GAP:  pat = 4'b0000;
            ST_B_ON:   pat = 4'b1100;
            ST_B_TAIL: pat = 4'b1000;
            ST_B_GAP:  pat = 4'b0000;
            default:   pat = 4'b0000;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_a      <= 1'b0;
            phase_a_late <= 1'b0;
            phase_b      <= 1'b0;
            phase_b_late <= 1'b0;
        end else begin
            phase_a      <= pat[0];
            phase_a_late <= pat[1];
            phase_b      <= pat[2];
            phase_b_late <= pat[3];
        end
    end

endmodule

// File: rtl/four_phase_clkgen.sv
module four_phase_clkgen
    import ncg_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  hold_cycles,
    input  logic [CNT_W-1:0]  trail_cycles,
    input  logic [CNT_W-1:0]  gap_cycles,
    output logic              phase_a,
    output logic              phase_a_late,
    output logic              phase_b,
    output logic              phase_b_late
);

    logic [FLD_NUM-1:0][CNT_W-1:0] raw_cfg;
    logic [FLD_NUM-1:0][CNT_W-1:0] cur_cfg;
    logic [CNT_W-1:0]              hold_next;
    logic                          period_start;
    ncg_state_e                    state_d;

    assign raw_cfg[FLD_HOLD]  = hold_cycles;
    assign raw_cfg[FLD_TRAIL] = trail_cycles;
    assign raw_cfg[FLD_GAP]   = gap_cycles;

    ncg_cfg_hold #(.CNT_W(CNT_W)) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (period_start),
        .raw_cfg   (raw_cfg),
        .hold_next (hold_next),
        .cur_cfg   (cur_cfg)
    );

    ncg_seq_fsm #(.CNT_W(CNT_W)) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .hold_next    (hold_next),
        .cur_cfg      (cur_cfg),
        .state_d      (state_d),
        .period_start (period_start)
    );

    ncg_phase_drive drv_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .state_d      (state_d),
        .phase_a      (phase_a),
        .phase_a_late (phase_a_late),
        .phase_b      (phase_b),
        .phase_b_late (phase_b_late)
    );

endmodule

// File: rtl/ncg_checker.sv
module ncg_checker (
    input logic clk,
    input logic rst_n,
    input logic phase_a,
    input logic phase_a_late,
    input logic phase_b,
    input logic phase_b_late
);

    // R1: outputs cleared while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_low_R1: assert ({phase_a, phase_a_late, phase_b, phase_b_late} == 4'b0000);
        end
    end

    assert_main_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(phase_a && phase_b));

    assert_late_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(phase_a_late && phase_b_late));

    assert_a_covered_R4: assert property (@(posedge clk) disable iff (!rst_n)
        phase_a |-> phase_a_late);

    assert_b_covered_R4: assert property (@(posedge clk) disable iff (!rst_n)
        phase_b |-> phase_b_late);

    assert_a_trails_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phase_a) |-> phase_a_late);

    assert_b_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_b) |-> !$past(phase_a_late));

    assert_a_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_a) |-> !$past(phase_b_late));

endmodule

bind four_phase_clkgen ncg_checker chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .phase_a      (phase_a),
    .phase_a_late (phase_a_late),
    .phase_b      (phase_b),
    .phase_b_late (phase_b_late)
);

// File: tb/four_phase_clkgen_tb.sv
module four_phase_clkgen_tb_top;

    localparam int CNT_W = 8;
    localparam int VEC_N = 6;
    // Each row: hold, trail, gap, expected period in master cycles
    localparam int TBL [VEC_N][4] = '{
        '{1, 1, 1, 6},
        '{4, 2, 3, 18},
        '{0, 0, 0, 6},
        '{2, 5, 1, 16},
        '{8, 1, 4, 26},
        '{3, 3, 0, 14}
    };

    logic             clk;
    logic             rst_n;
    logic [CNT_W-1:0] hold_cycles;
    logic [CNT_W-1:0] trail_cycles;
    logic [CNT_W-1:0] gap_cycles;
    logic             phase_a, phase_a_late, phase_b, phase_b_late;

    int checks;
    int errors;

    four_phase_clkgen #(.CNT_W(CNT_W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .hold_cycles  (hold_cycles),
        .trail_cycles (trail_cycles),
        .gap_cycles   (gap_cycles),
        .phase_a      (phase_a),
        .phase_a_late (phase_a_late),
        .phase_b      (phase_b),
        .phase_b_late (phase_b_late)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    // Positional reference derived from the requirements
    function automatic int clampv(input logic [CNT_W-1:0] v);
        return (v == '0) ? 1 : int'(v);
    endfunction

    logic m_run;
    int   m_pos, m_hold, m_trail, m_gap;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run <= 1'b0;
            m_pos <= 0;
            m_hold <= 1; m_trail <= 1; m_gap <= 1;
        end else if (!m_run || m_pos == 2*(m_hold+m_trail+m_gap)-1) begin
            m_run   <= 1'b1;
            m_pos   <= 0;
            m_hold  <= clampv(hold_cycles);
            m_trail <= clampv(trail_cycles);
            m_gap   <= clampv(gap_cycles);
        end else begin
            m_pos <= m_pos + 1;
        end
    end

    function automatic logic [3:0] expect_pat();
        int half, h;
        logic first;
        if (!m_run) return 4'b0000;
        half  = m_hold + m_trail + m_gap;
        first = (m_pos < half);
        h     = first ? m_pos : m_pos - half;
        // {b_late, b, a_late, a}
        if (first) return {2'b00, (h < m_hold + m_trail), (h < m_hold)};
        return {(h < m_hold + m_trail), (h < m_hold), 2'b00};
    endfunction

    // Observation state
    int cyc;
    int rise_at [4];
    int rise_n;
    logic prev_a;
    int ovl_main, ovl_late, lead_err, wave_err;
    logic [3:0] last_got, last_exp;

    task automatic clear_obs();
        cyc = 0; rise_n = 0; prev_a = 1'b0;
        ovl_main = 0; ovl_late = 0; lead_err = 0; wave_err = 0;
        last_got = '0; last_exp = '0;
    endtask

    task automatic observe(input int n);
        logic [3:0] got, exp_v;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            got   = {phase_b_late, phase_b, phase_a_late, phase_a};
            exp_v = expect_pat();
            if (phase_a && phase_b) ovl_main++;
            if (phase_a_late && phase_b_late) ovl_late++;
            if ((phase_a && !phase_a_late) || (phase_b && !phase_b_late)) lead_err++;
            if (got !== exp_v) begin
                wave_err++;
                last_got = got;
                last_exp = exp_v;
            end
            if (phase_a && !prev_a && rise_n < 4) begin
                rise_at[rise_n] = cyc;
                rise_n++;
            end
            prev_a = phase_a;
            cyc++;
        end
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    task automatic start_run(input int h, input int t, input int g);
        @(negedge clk);
        rst_n = 1'b0;
        hold_cycles  = CNT_W'(h);
        trail_cycles = CNT_W'(t);
        gap_cycles   = CNT_W'(g);
        repeat (3) @(negedge clk);
        check({phase_b_late, phase_b, phase_a_late, phase_a} == 4'b0000,
              "R1 outputs low in reset", int'({phase_b_late, phase_b, phase_a_late, phase_a}), 0);
        rst_n = 1'b1;
        clear_obs();
    endtask

    initial begin
        checks = 0; errors = 0;
        rst_n = 1'b0;
        hold_cycles = '0; trail_cycles = '0; gap_cycles = '0;

        // Table walk
        for (int v = 0; v < VEC_N; v++) begin
            start_run(TBL[v][0], TBL[v][1], TBL[v][2]);
            observe(3 * TBL[v][3]);
            check(rise_n >= 1 && rise_at[0] == 0, "R10 first rise after reset", rise_at[0], 0);
            check(ovl_main == 0, "R2 main overlap", ovl_main, 0);
            check(ovl_late == 0, "R3 late overlap", ovl_late, 0);
            check(lead_err == 0, "R4 late covers main", lead_err, 0);
            check(wave_err == 0, "R5 R6 R7 R8 waveform", int'(last_got), int'(last_exp));
            check(rise_n >= 2 && rise_at[1] - rise_at[0] == TBL[v][3],
                  "R10 period", rise_at[1] - rise_at[0], TBL[v][3]);
        end

        // R9: change settings during the tail of phase A
        start_run(4, 2, 3);
        observe(5);
        hold_cycles = 8'd1; trail_cycles = 8'd1; gap_cycles = 8'd1;
        observe(40);
        check(rise_n >= 3 && rise_at[1] - rise_at[0] == 18,
              "R9 old period kept", rise_at[1] - rise_at[0], 18);
        check(rise_n >= 3 && rise_at[2] - rise_at[1] == 6,
              "R9 new period applied", rise_at[2] - rise_at[1], 6);
        check(wave_err == 0, "R9 waveform across change", int'(last_got), int'(last_exp));

        // R1: asynchronous clear in the middle of phase A
        start_run(5, 2, 2);
        observe(2);
        #1 rst_n = 1'b0;
        #0.5;
        check({phase_b_late, phase_b, phase_a_late, phase_a} == 4'b0000,
              "R1 async clear mid-run", int'({phase_b_late, phase_b, phase_a_late, phase_a}), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule